// File: doc/BRIEF.md
# Steered Replicated Register Bank

This block holds one logical register that exists as a separate copy in each hardware unit. The units are arranged as a grid of groups, each with several instances. All copies sit behind a single data address on a simple memory-mapped slave port. A steering register chooses which copy an access reaches. It also holds a mode bit. When the mode bit is set, a write fans out to every copy. When it is clear, a write reaches only the steered copy. A read always returns the one steered copy, whatever the mode bit holds.

A per-unit enable input marks each unit as present and powered. An access steered to a unit whose enable is low is terminated without any error: a read returns zero and a unicast write has no effect. A fan-out write also skips every disabled unit, so the copy in that unit keeps its old value. A hardware semaphore lets several bus agents, each identified by a requester ID, take turns owning the steering register. The semaphore is a two-state machine with the states SEM_FREE and SEM_HELD. The transition ACQUIRE moves it from SEM_FREE to SEM_HELD when any agent reads the semaphore address. The transition RELEASE moves it from SEM_HELD back to SEM_FREE when the owning agent writes 1 to that address. The defaults are 2 groups, 4 instances per group and 32 data bits.

The slave port uses four word addresses. Address 0 is the replicated data register. Address 1 is the steering register. Address 2 is the semaphore. Address 3 reads as zero and ignores writes. Every access completes in one cycle. Read data is registered and appears in the following cycle, marked by `rd_valid`.

Top module: `steered_copy_bank`

## Requirements
- R1: After reset every copy reads 0. The steering register reads 0x0001_0000, which is mode bit set, group 0 and instance 0. The semaphore is in SEM_FREE, so the first semaphore read returns 1.
- R2: With the mode bit (steering bit 16) set, a write to address 0 stores the write data in every copy whose unit enable is high.
- R3: With the mode bit clear, a write to address 0 stores the data only in the unit numbered group*INSTANCES+instance. Every other copy is unchanged.
- R4: A read of address 0 returns the steered copy alone, with the mode bit either set or clear.
- R5: A read of address 0 steered to a unit whose enable is low returns 0.
- R6: A unicast write steered to a disabled unit is dropped. Once the unit is enabled again it reads its earlier value.
- R7: A fan-out write leaves the copy of every disabled unit at its old value.
- R8: The steering register reads back as written. The instance is in bits starting at 0, the group in bits starting at 8 and the mode bit is bit 16. All other bits read 0.
- R9: A semaphore read (address 2) while in SEM_FREE returns 1 and takes the transition ACQUIRE, recording the requester ID as owner. While in SEM_HELD a read returns 1 to the owner and 0 to any other requester.
- R10: A write of 1 to address 2 by the owner takes the transition RELEASE. A write by any other requester, or a write of 0, leaves the semaphore held.
- R11: `rd_valid` is high exactly in the cycle after a read was accepted. `rd_data` carries that read's value in the same cycle. Writes never raise `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_valid | input | 1 | Access request this cycle |
| bus_write | input | 1 | 1 for write, 0 for read |
| bus_addr | input | 2 | Word address: 0 data, 1 steering, 2 semaphore, 3 spare |
| bus_wdata | input | DATA_W | Write data |
| bus_req_id | input | ID_W | Requester identity, used by the semaphore |
| unit_en | input | GROUPS*INSTANCES | Per-unit present and powered flags, bit n is unit n |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | DATA_W | Registered read data |

## Verification
The assertions take for granted that every bus signal is a known value whenever `bus_valid` is high. They also take for granted that `unit_en` changes only at clock edges, the same as any other synchronous input. The bench drives every input on the falling edge and holds it for a full cycle. It returns `bus_valid` low between accesses. It changes `unit_en` only while the bus is idle, so each check of a terminated access sees a stable enable pattern.

// File: rtl/rbank_pkg.sv
package rbank_pkg;
    typedef enum logic [1:0] {
        ADR_DATA  = 2'd0,
        ADR_STEER = 2'd1,
        ADR_SEM   = 2'd2,
        ADR_SPARE = 2'd3
    } adr_e;

    typedef enum logic {
        SEM_FREE = 1'b0,
        SEM_HELD = 1'b1
    } sem_state_e;

    localparam int INST_LSB = 0;
    localparam int GRP_LSB  = 8;
    localparam int MODE_BIT = 16;
endpackage

// File: rtl/steer_select.sv
module steer_select #(
    parameter int GW = 1,
    parameter int IW = 2,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          wmode,
    input  logic [GW-1:0] wgrp,
    input  logic [IW-1:0] winst,
    output logic          mcast,
    output logic [GW-1:0] grp,
    output logic [IW-1:0] inst,
    output logic [DW-1:0] word
);
    import rbank_pkg::*;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mcast <= 1'b1;
            grp   <= '0;
            inst  <= '0;
        end else if (wr) begin
            mcast <= wmode;
            grp   <= wgrp;
            inst  <= winst;
        end
    end

    always_comb begin
        word                  = '0;
        word[MODE_BIT]        = mcast;
        word[GRP_LSB +: GW]   = grp;
        word[INST_LSB +: IW]  = inst;
    end

    // R8: a steering write is visible in the following cycle
    a_r8_mode_loads: assert property (@(posedge clk) disable iff (!rst_n)
        wr |=> (mcast == $past(wmode)) && (grp == $past(wgrp)));
endmodule

// File: rtl/steer_sem.sv
module steer_sem #(
    parameter int IDW = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           sem_rd,
    input  logic           sem_wr,
    input  logic           wbit,
    input  logic [IDW-1:0] req_id,
    output logic           grant
);
    import rbank_pkg::*;

    sem_state_e     state_q, state_d;
    logic [IDW-1:0] owner_q, owner_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SEM_FREE;
            owner_q <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
        end
    end

    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        grant   = 1'b0;
        unique case (state_q)
            SEM_FREE: begin
                grant = 1'b1;
                if (sem_rd) begin            // ACQUIRE
                    state_d = SEM_HELD;
                    owner_d = req_id;
                end
            end
            SEM_HELD: begin
                grant = (owner_q == req_id);
                if (sem_wr && wbit && owner_q == req_id) begin  // RELEASE
                    state_d = SEM_FREE;
                end
            end
            default: state_d = SEM_FREE;
        endcase
    end

    // R9: acquiring records the requester as owner
    a_r9_acquire_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_FREE && sem_rd) |=> (state_q == SEM_HELD && owner_q == $past(req_id)));

    // R10: a foreign requester cannot release
    a_r10_foreign_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SEM_HELD && sem_wr && req_id != owner_q) |=> (state_q == SEM_HELD && $stable(owner_q)));
endmodule

// File: rtl/copy_array.sv
module copy_array #(
    parameter int NG = 2,
    parameter int NI = 4,
    parameter int DW = 32,
    parameter int GW = 1,
    parameter int IW = 2,
    localparam int NU = NG * NI
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          mcast,
    input  logic [GW-1:0] grp,
    input  logic [IW-1:0] inst,
    input  logic [DW-1:0] wdata,
    input  logic [NU-1:0] unit_en,
    output logic [DW-1:0] rd_val,
    output logic          rd_live
);
    logic [DW-1:0] copy_q [NU];
    logic [NU-1:0] wen;
    logic [NU-1:0] hit;
    logic          in_range;
    int            tgt;

    always_comb begin
        in_range = (int'(grp) < NG) && (int'(inst) < NI);
        tgt      = int'(grp) * NI + int'(inst);
    end

    for (genvar u = 0; u < NU; u++) begin : g_unit
        assign hit[u] = in_range && (tgt == u);
        assign wen[u] = wr && unit_en[u] && (mcast || hit[u]);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      copy_q[u] <= '0;
            else if (wen[u]) copy_q[u] <= wdata;
        end

        // R2: fan-out write reaches an enabled unit
        a_r2_fanout: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && mcast && unit_en[u]) |=> (copy_q[u] == $past(wdata)));

        // R6 / R7: a disabled unit never changes on a write
        a_r7_disabled_kept: assert property (@(posedge clk) disable iff (!rst_n)
            (wr && !unit_en[u]) |=> $stable(copy_q[u]));
    end

    always_comb begin
        rd_val  = '0;
        rd_live = 1'b0;
        for (int u = 0; u < NU; u++) begin
            if (hit[u] && unit_en[u]) begin
                rd_val  = copy_q[u];
                rd_live = 1'b1;
            end
        end
    end

    // R3: a unicast write touches at most one copy
    a_r3_single_target: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !mcast) |-> $onehot0(wen));
endmodule

// File: rtl/steered_copy_bank.sv
module steered_copy_bank #(
    parameter int GROUPS    = 2,
    parameter int INSTANCES = 4,
    parameter int DATA_W    = 32,
    parameter int ID_W      = 2,
    localparam int NU = GROUPS * INSTANCES,
    localparam int GW = (GROUPS > 1) ? $clog2(GROUPS) : 1,
    localparam int IW = (INSTANCES > 1) ? $clog2(INSTANCES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic [ID_W-1:0]   bus_req_id,
    input  logic [NU-1:0]     unit_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data
);
    import rbank_pkg::*;

    logic              acc_rd, acc_wr;
    logic              mcast;
    logic [GW-1:0]     grp;
    logic [IW-1:0]     inst;
    logic [DATA_W-1:0] steer_word;
    logic [DATA_W-1:0] copy_val;
    logic              copy_live;
    logic              grant;
    logic [DATA_W-1:0] rd_next;

    assign acc_rd = bus_valid && !bus_write;
    assign acc_wr = bus_valid && bus_write;

    steer_select #(.GW(GW), .IW(IW), .DW(DATA_W)) u_sel (
        .clk   (clk),
        .rst_n (rst_n),
        .wr    (acc_wr && bus_addr == ADR_STEER),
        .wmode (bus_wdata[MODE_BIT]),
        .wgrp  (bus_wdata[GRP_LSB +: GW]),
        .winst (bus_wdata[INST_LSB +: IW]),
        .mcast (mcast),
        .grp   (grp),
        .inst  (inst),
        .word  (steer_word)
    );

    steer_sem #(.IDW(ID_W)) u_sem (
        .clk    (clk),
        .rst_n  (rst_n),
        .sem_rd (acc_rd && bus_addr == ADR_SEM),
        .sem_wr (acc_wr && bus_addr == ADR_SEM),
        .wbit   (bus_wdata[0]),
        .req_id (bus_req_id),
        .grant  (grant)
    );

    copy_array #(.NG(GROUPS), .NI(INSTANCES), .DW(DATA_W), .GW(GW), .IW(IW)) u_arr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (acc_wr && bus_addr == ADR_DATA),
        .mcast   (mcast),
        .grp     (grp),
        .inst    (inst),
        .wdata   (bus_wdata),
        .unit_en (unit_en),
        .rd_val  (copy_val),
        .rd_live (copy_live)
    );

    always_comb begin
        unique case (adr_e'(bus_addr))
            ADR_DATA:  rd_next = copy_val;
            ADR_STEER: rd_next = steer_word;
            ADR_SEM:   rd_next = {{(DATA_W-1){1'b0}}, grant};
            default:   rd_next = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= acc_rd;
            if (acc_rd) rd_data <= rd_next;
        end
    end

    // R5: a terminated read returns zero
    a_r5_terminated_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_rd && bus_addr == ADR_DATA && !copy_live) |=> (rd_data == '0));

    // R11: read data is flagged only after an accepted read
    a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(acc_rd));
endmodule

// File: tb/steered_copy_bank_tb.sv
module steered_copy_bank_tb;
    localparam int NU = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [1:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [1:0]  bus_req_id = '0;
    logic [NU-1:0] unit_en = '1;
    logic        rd_valid;
    logic [31:0] rd_data;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    steered_copy_bank u_dut (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_req_id(bus_req_id),
        .unit_en(unit_en), .rd_valid(rd_valid), .rd_data(rd_data)
    );

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    function automatic logic [31:0] steer(input int g, input int i, input bit m);
        return (32'(m) << 16) | (32'(g) << 8) | 32'(i);
    endfunction

    task automatic do_write(input logic [1:0] a, input logic [31:0] d, input logic [1:0] id);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d; bus_req_id = id;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
        check("R11 write no rd_valid", {31'b0, rd_valid}, 32'd0);
    endtask

    task automatic do_read(input logic [1:0] a, input logic [1:0] id, output logic [31:0] d);
        @(negedge clk);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a; bus_req_id = id;
        @(negedge clk);
        bus_valid = 1'b0;
        check("R11 read rd_valid", {31'b0, rd_valid}, 32'd1);
        d = rd_data;
    endtask

    task automatic read_unit(input int u, input bit m, output logic [31:0] d);
        do_write(2'd1, steer(u / 4, u % 4, m), 2'd0);
        do_read(2'd0, 2'd0, d);
    endtask

    task automatic t_reset;
        logic [31:0] d;
        do_read(2'd1, 2'd0, d);
        check("R1 steering reset", d, 32'h0001_0000);
        do_read(2'd0, 2'd0, d);
        check("R1 copy0 reset", d, 32'd0);
        do_read(2'd2, 2'd1, d);
        check("R1 semaphore free", d, 32'd1);
        do_write(2'd2, 32'd1, 2'd1);
        read_unit(7, 1'b1, d);
        check("R1 copy7 reset", d, 32'd0);
    endtask

    task automatic t_fanout;
        logic [31:0] d;
        do_write(2'd1, steer(0, 0, 1'b1), 2'd0);
        do_write(2'd0, 32'hA5A5_0001, 2'd0);
        for (int u = 0; u < NU; u++) begin
            read_unit(u, u[0], d);
            check("R2 fan-out copy", d, 32'hA5A5_0001);
        end
    endtask

    task automatic t_unicast;
        logic [31:0] d;
        do_write(2'd1, steer(1, 2, 1'b0), 2'd0);
        do_write(2'd0, 32'h0000_1234, 2'd0);
        read_unit(6, 1'b1, d);
        check("R3 target copy", d, 32'h0000_1234);
        read_unit(5, 1'b0, d);
        check("R3 neighbour copy", d, 32'hA5A5_0001);
        read_unit(2, 1'b0, d);
        check("R3 same instance other group", d, 32'hA5A5_0001);
        read_unit(6, 1'b0, d);
        check("R4 read in unicast mode", d, 32'h0000_1234);
    endtask

    task automatic t_steer_layout;
        logic [31:0] d;
        do_write(2'd1, 32'hFFFE_FEFF & steer(1, 3, 1'b0) | steer(1, 3, 1'b0), 2'd0);
        do_read(2'd1, 2'd0, d);
        check("R8 readback unicast", d, 32'h0000_0103);
        do_write(2'd1, 32'hFFFF_FFFF, 2'd0);
        do_read(2'd1, 2'd0, d);
        check("R8 readback all ones", d, 32'h0001_0103);
    endtask

    task automatic t_disabled;
        logic [31:0] d;
        @(negedge clk);
        unit_en = 8'b1111_0111;
        read_unit(3, 1'b0, d);
        check("R5 disabled read zero", d, 32'd0);
        do_write(2'd1, steer(0, 3, 1'b0), 2'd0);
        do_write(2'd0, 32'h0000_DEAD, 2'd0);
        do_write(2'd1, steer(0, 0, 1'b1), 2'd0);
        do_write(2'd0, 32'h0000_0077, 2'd0);
        read_unit(4, 1'b1, d);
        check("R7 enabled unit took fan-out", d, 32'h0000_0077);
        @(negedge clk);
        unit_en = '1;
        read_unit(3, 1'b0, d);
        check("R6 R7 disabled copy kept", d, 32'hA5A5_0001);
    endtask

    task automatic t_sem;
        logic [31:0] d;
        do_read(2'd2, 2'd2, d);
        check("R9 acquire returns 1", d, 32'd1);
        do_read(2'd2, 2'd2, d);
        check("R9 owner reread", d, 32'd1);
        do_read(2'd2, 2'd3, d);
        check("R9 other agent blocked", d, 32'd0);
        do_write(2'd2, 32'd1, 2'd3);
        do_read(2'd2, 2'd3, d);
        check("R10 foreign release ignored", d, 32'd0);
        do_write(2'd2, 32'd0, 2'd2);
        do_read(2'd2, 2'd3, d);
        check("R10 write of 0 ignored", d, 32'd0);
        do_write(2'd2, 32'd1, 2'd2);
        do_read(2'd2, 2'd3, d);
        check("R10 release then acquire", d, 32'd1);
        do_read(2'd2, 2'd2, d);
        check("R10 previous owner now blocked", d, 32'd0);
        do_write(2'd2, 32'd1, 2'd3);
    endtask

    task automatic t_spare;
        logic [31:0] d;
        do_write(2'd3, 32'hFFFF_FFFF, 2'd0);
        do_read(2'd3, 2'd0, d);
        check("R11 spare reads zero", d, 32'd0);
    endtask

    initial begin
        fork
            begin
                repeat (5) @(negedge clk);
                rst_n = 1'b1;
                @(negedge clk);
                check("R11 idle after reset", {31'b0, rd_valid}, 32'd0);
                t_reset();
                t_fanout();
                t_unicast();
                t_steer_layout();
                t_disabled();
                t_sem();
                t_spare();
            end
            begin
                repeat (20000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule